// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block lets a host read and write registers inside an external PHY over the two-wire management bus. The host sees two 32-bit windows, picked by a single select input. The address-setup window holds a port address, a device address and a 16-bit register address. Any read or write to the data window starts a complete indirect access on the bus. That access is two back-to-back 64-bit frames. An address frame loads the register address into the PHY. Then a write frame carries the host's data, or a read frame brings the PHY's data back.

MDC comes from the system clock through a divider. The block drives MDIO through an output-enable pin. During read frames it releases the line for the turnaround and data bits. It samples the PHY's 16 data bits on the rising edges of MDC. A data-window access stays stalled by the wait output until its second frame has ended. For a read, the returned word is the value sampled from that read frame.

The sequencer has five states, all named here:
- `C_IDLE`: moves to `C_ADDR_RUN` when a data-window access arrives, and starts the address frame.
- `C_ADDR_RUN`: moves to `C_DATA_LOAD` when the frame ends.
- `C_DATA_LOAD`: starts the write or read frame, then moves to `C_DATA_RUN`.
- `C_DATA_RUN`: moves to `C_DONE` when the frame ends.
- `C_DONE`: the one cycle in which the access completes, then back to `C_IDLE`.

The frame engine has three states:
- `F_IDLE`: moves to `F_LOW` on a start.
- `F_LOW`: moves to `F_HIGH` after half an MDC period.
- `F_HIGH`: after half an MDC period, moves back to `F_LOW` for the next bit, or to `F_IDLE` after bit 63.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, MDC is low, the output enable is low, the wait output is low while no access is presented, and the address-setup window reads 0.
- R2: A write to the address-setup window (select = 1) takes effect at once when idle. Bits 15:0 hold the register address, 20:16 the device address and 25:21 the port address. A read returns these fields at the same positions.
- R3: Every data-window access (select = 0) produces exactly two 64-bit frames. The address frame comes first, then the write or read frame. Both begin with 32 ones.
- R4: After the preamble, each frame carries, MSB first: start 00, then an opcode (00 address, 01 write, 11 read), then the 5-bit port, then the 5-bit device, then 2 turnaround bits, then a 16-bit field. The field is the register address in the address frame and write-data bits 15:0 in the write frame.
- R5: MDC runs at the system clock divided by the even parameter MDC_DIV, with equal high and low halves, and stays low between frames. MDIO and its enable change only while MDC is low.
- R6: In address and write frames the master drives turnaround as 1 then 0. In a read frame it releases MDIO from the first turnaround bit to the end of the frame. The enable is low whenever no frame is running.
- R7: A data-window read returns, in bits 15:0, the 16 bits sampled on MDC rising edges during the read frame's data phase, MSB first. Bits 31:16 read 0.
- R8: A data-window access holds the wait output high from its first cycle until the read or write frame has ended, then lowers it for the completing cycle.
- R9: Bits 31:26 written to the address-setup window are ignored and read back as 0.
- R10: Bits 31:16 of a data-window write are ignored: the write frame's field equals bits 15:0.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_win | input | 1 | Window select: 1 address setup, 0 data |
| csr_rd | input | 1 | Read request, held until wait is low |
| csr_wr | input | 1 | Write request, held until wait is low |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid when wait is low |
| csr_wait | output | 1 | Stall for the current access |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value as seen at the pin |

## Verification
The bench includes a PHY responder. It checks every 64-bit frame bit by bit, so an opcode swap, a port/device swap or a missing turnaround shows up as a frame mismatch. The responder drives its stored data during reads. A design that sampled on the wrong MDC edge, or released MDIO one bit late, would return shifted read data or fight the PHY on the turnaround bit. The bench also checks the MDC period and the stall length of each access. A design that dropped the wait output after the address frame, or ran only one frame, would finish early. Write data and the address-setup window are loaded with extreme values and garbage in the upper bits, which exposes any bit that leaks past its field.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b11
    } mdio_op_e;

    typedef enum logic [2:0] {
        C_IDLE,
        C_ADDR_RUN,
        C_DATA_LOAD,
        C_DATA_RUN,
        C_DONE
    } ctrl_state_e;

    typedef enum logic [1:0] {
        F_IDLE,
        F_LOW,
        F_HIGH
    } frm_state_e;

    // Packed so that port sits in bits 25:21, device in 20:16, register in 15:0.
    typedef struct packed {
        logic [4:0]  port;
        logic [4:0]  dev;
        logic [15:0] reg_a;
    } addr_cfg_t;

endpackage

// File: rtl/mdio_cfg_regs.sv
module mdio_cfg_regs
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [25:0] wdata,
    output addr_cfg_t   cfg,
    output logic [31:0] rdback
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg <= addr_cfg_t'(wdata);
        end
    end

    always_comb begin
        rdback = {6'b0, cfg};
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int MDC_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_op_e    op,
    input  logic [4:0]  port,
    input  logic [4:0]  dev,
    input  logic [15:0] field,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        busy,
    output logic        done,
    output logic [15:0] cap
);

    localparam int HALF = MDC_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int IW   = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] HLAST    = CW'(HALF - 1);
    localparam logic [IW-1:0] LAST_BIT = IW'(FRAME_BITS - 1);

    frm_state_e            st, st_n;
    logic [CW-1:0]         hcnt;
    logic [IW-1:0]         bidx;
    logic [FRAME_BITS-1:0] shreg;
    logic                  rd_frame;
    logic                  half_end;
    logic [1:0]            ta_bits;

    assign half_end = (hcnt == HLAST);
    assign ta_bits  = (op == OP_READ) ? 2'b11 : 2'b10;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= F_IDLE;
        else        st <= st_n;
    end

    // Next state
    always_comb begin
        st_n = st;
        unique case (st)
            F_IDLE:  if (start)    st_n = F_LOW;
            F_LOW:   if (half_end) st_n = F_HIGH;
            F_HIGH:  if (half_end) st_n = (bidx == LAST_BIT) ? F_IDLE : F_LOW;
            default: st_n = F_IDLE;
        endcase
    end

    // Divider, shifter and capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt     <= '0;
            bidx     <= '0;
            shreg    <= '0;
            rd_frame <= 1'b0;
            cap      <= '0;
            done     <= 1'b0;
        end else begin
            done <= (st == F_HIGH) && half_end && (bidx == LAST_BIT);
            if (st == F_IDLE || half_end) hcnt <= '0;
            else                          hcnt <= hcnt + 1'b1;
            if (st == F_IDLE && start) begin
                shreg    <= {{PRE_BITS{1'b1}}, 2'b00, op, port, dev, ta_bits, field};
                bidx     <= '0;
                rd_frame <= (op == OP_READ);
            end
            if (st == F_LOW && half_end && rd_frame && bidx >= IW'(DATA_FIRST)) begin
                cap <= {cap[14:0], mdio_i};
            end
            if (st == F_HIGH && half_end && bidx != LAST_BIT) begin
                bidx  <= bidx + 1'b1;
                shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // Outputs
    always_comb begin
        mdc     = (st == F_HIGH);
        busy    = (st != F_IDLE);
        mdio_o  = shreg[FRAME_BITS-1];
        mdio_oe = (st != F_IDLE) && !(rd_frame && bidx >= IW'(TA_FIRST));
    end

    // Checker state: rising edges per frame and length of each high phase
    logic [6:0] rise_cnt;
    int         hi_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            hi_len   <= 0;
        end else begin
            if (st == F_IDLE && start)       rise_cnt <= '0;
            else if (st == F_LOW && half_end) rise_cnt <= rise_cnt + 1'b1;
            hi_len <= mdc ? hi_len + 1 : 0;
        end
    end

    a_r3_sixty_four_rises: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rise_cnt == 7'd64));

    a_r5_mdio_quiet_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    a_r5_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> (hi_len < HALF));

    a_r4_preamble_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bidx < IW'(PRE_BITS)) |-> (mdio_o && mdio_oe));

endmodule

// File: rtl/mdio_seq_ctrl.sv
module mdio_seq_ctrl
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_data,
    input  logic        acc_wr,
    input  addr_cfg_t   cfg,
    input  logic [15:0] wdata,
    input  logic        eng_done,
    input  logic        eng_busy,
    input  logic [15:0] eng_cap,
    output logic        start,
    output mdio_op_e    op,
    output logic [15:0] field,
    output logic        wait_o,
    output logic        busy,
    output logic [15:0] rd_q
);

    ctrl_state_e st, st_n;
    logic        cmd_wr;
    logic [15:0] wq;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= st_n;
    end

    // Next state
    always_comb begin
        st_n = st;
        unique case (st)
            C_IDLE:      if (acc_data) st_n = C_ADDR_RUN;
            C_ADDR_RUN:  if (eng_done) st_n = C_DATA_LOAD;
            C_DATA_LOAD: st_n = C_DATA_RUN;
            C_DATA_RUN:  if (eng_done) st_n = C_DONE;
            C_DONE:      st_n = C_IDLE;
            default:     st_n = C_IDLE;
        endcase
    end

    // Command capture and read-data latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_wr <= 1'b0;
            wq     <= '0;
            rd_q   <= '0;
        end else begin
            if (st == C_IDLE && acc_data) begin
                cmd_wr <= acc_wr;
                wq     <= wdata;
            end
            if (st == C_DATA_RUN && eng_done && !cmd_wr) begin
                rd_q <= eng_cap;
            end
        end
    end

    // Outputs
    always_comb begin
        start  = 1'b0;
        op     = OP_ADDR;
        field  = cfg.reg_a;
        wait_o = acc_data && (st != C_DONE);
        busy   = (st != C_IDLE);
        unique case (st)
            C_IDLE:      start = acc_data;
            C_DATA_LOAD: begin
                start = 1'b1;
                op    = cmd_wr ? OP_WRITE : OP_READ;
                field = cmd_wr ? wq : 16'h0000;
            end
            default: ;
        endcase
    end

    // Checker: frames started per access
    logic [1:0] n_start;

    always_ff @(posedge clk) begin
        if (!rst_n)            n_start <= '0;
        else if (st == C_IDLE) n_start <= start ? 2'd1 : 2'd0;
        else if (start)        n_start <= n_start + 1'b1;
    end

    a_r3_two_frames: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_DONE) |-> (n_start == 2'd2));

    a_r8_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_data && eng_busy) |-> wait_o);

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
    import mdio_pkg::*;
#(
    parameter int MDC_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_win,
    input  logic        csr_rd,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        csr_wait,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);

    addr_cfg_t   cfg;
    logic [31:0] cfg_rd;
    logic        acc_any, acc_data, acc_cfg;
    logic        start, eng_busy, eng_done, data_wait, ctrl_busy;
    mdio_op_e    op;
    logic [15:0] field, cap, rd_q;
    logic        unused_wbits;

    assign unused_wbits = ^csr_wdata[31:26];
    assign acc_any  = csr_rd || csr_wr;
    assign acc_data = acc_any && !csr_win;
    assign acc_cfg  = acc_any && csr_win;

    mdio_cfg_regs u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (acc_cfg && csr_wr && !ctrl_busy),
        .wdata  (csr_wdata[25:0]),
        .cfg    (cfg),
        .rdback (cfg_rd)
    );

    mdio_seq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_data (acc_data),
        .acc_wr   (csr_wr),
        .cfg      (cfg),
        .wdata    (csr_wdata[15:0]),
        .eng_done (eng_done),
        .eng_busy (eng_busy),
        .eng_cap  (cap),
        .start    (start),
        .op       (op),
        .field    (field),
        .wait_o   (data_wait),
        .busy     (ctrl_busy),
        .rd_q     (rd_q)
    );

    mdio_frame_engine #(
        .MDC_DIV (MDC_DIV)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op      (op),
        .port    (cfg.port),
        .dev     (cfg.dev),
        .field   (field),
        .mdio_i  (mdio_i),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .busy    (eng_busy),
        .done    (eng_done),
        .cap     (cap)
    );

    always_comb begin
        csr_wait  = data_wait || (acc_cfg && ctrl_busy);
        csr_rdata = csr_win ? cfg_rd : {16'h0000, rd_q};
    end

    a_r6_release_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdio_oe);

    a_r5_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !mdc);

endmodule

// File: tb/sim_mdio_c45_master.sv
module sim_mdio_c45_master;

    localparam int DIV = 4;
    localparam int ACC_MIN = 2 * 64 * DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_win = 1'b0, csr_rd = 1'b0, csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_wait, mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_en = 1'b0, phy_val = 1'b0;

    always #10 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    mdio_c45_master #(.MDC_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .csr_win(csr_win), .csr_rd(csr_rd), .csr_wr(csr_wr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_wait(csr_wait),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_frame(input logic [1:0] op, input logic [4:0] p,
                                             input logic [4:0] d, input logic [1:0] ta,
                                             input logic [15:0] f);
        return {32'hFFFF_FFFF, 2'b00, op, p, d, ta, f};
    endfunction

    // Expected frames for the access in flight
    logic [63:0] exp_f [2];
    bit          exp_rd;
    int          nf;
    logic [15:0] shadow [32];

    // PHY responder
    int          pos = 0;
    logic [63:0] rxsh = '0;
    logic [15:0] phy_mem [32];
    logic [15:0] phy_ra = '0;
    logic [15:0] phy_word = '0;
    realtime     last_rise = 0;

    always @(posedge mdc) begin
        logic [63:0] full;
        full = {rxsh[62:0], mdio_i};
        if (pos == 10) chk(($realtime - last_rise) == DIV * 20, "R5 mdc period",
                           64'($rtoi($realtime - last_rise)), 64'(DIV * 20));
        last_rise = $realtime;
        if (pos == 46 && {full[12], full[11]} == 2'b11) begin
            chk(!mdio_oe, "R6 read turnaround released", 64'(mdio_oe), 64'd0);
            phy_word <= phy_mem[phy_ra[4:0]];
            phy_en   <= 1'b1;
            phy_val  <= 1'b0;
        end
        if (pos >= 47 && pos <= 62 && phy_en) phy_val <= phy_word[62 - pos];
        if (pos == 63) begin
            phy_en <= 1'b0;
            if (nf > 1) begin
                chk(1'b0, "R3 extra frame", 64'(nf), 64'd1);
            end else if (exp_rd && nf == 1) begin
                chk(full[63:18] == exp_f[1][63:18], "R3 R4 read frame header",
                    {18'b0, full[63:18]}, {18'b0, exp_f[1][63:18]});
            end else begin
                chk(full == exp_f[nf], "R3 R4 R6 R10 frame bits", full, exp_f[nf]);
            end
            nf++;
            if (full[29:28] == 2'b00) phy_ra <= full[15:0];
            else if (full[29:28] == 2'b01) phy_mem[phy_ra[4:0]] <= full[15:0];
            pos = 0;
        end else begin
            pos = pos + 1;
        end
        rxsh = full;
    end

    task automatic access(input bit win, input bit wr, input logic [31:0] wd,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        csr_win = win; csr_wr = wr; csr_rd = !wr; csr_wdata = wd;
        cyc = 0;
        #1;
        while (csr_wait && cyc < 5000) begin
            @(negedge clk);
            #1;
            cyc++;
        end
        rd = csr_rdata;
        @(posedge clk);
        #1;
        csr_rd = 1'b0; csr_wr = 1'b0;
    endtask

    task automatic data_op(input bit wr, input logic [4:0] p, input logic [4:0] d,
                           input logic [15:0] ra, input logic [31:0] wd);
        logic [31:0] rd;
        int          cyc;
        access(1'b1, 1'b1, {6'h2A, p, d, ra}, rd, cyc);
        exp_f[0] = mk_frame(2'b00, p, d, 2'b10, ra);
        exp_f[1] = wr ? mk_frame(2'b01, p, d, 2'b10, wd[15:0]) : mk_frame(2'b11, p, d, 2'b00, 16'h0);
        exp_rd = !wr;
        nf = 0;
        access(1'b0, wr, wd, rd, cyc);
        chk(nf == 2, "R3 two frames per access", 64'(nf), 64'd2);
        chk(cyc >= ACC_MIN && cyc <= ACC_MIN + 6, "R8 stall spans both frames", 64'(cyc), 64'(ACC_MIN));
        if (wr) begin
            shadow[ra[4:0]] = wd[15:0];
        end else begin
            chk(rd == {16'h0, shadow[ra[4:0]]}, "R7 read data", 64'(rd), 64'({16'h0, shadow[ra[4:0]]}));
        end
        #3;
        chk(!mdc && !mdio_oe, "R5 R6 idle between accesses", 64'({mdc, mdio_oe}), 64'd0);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int          cyc;
        void'($urandom(32'd20240613));
        for (int i = 0; i < 32; i++) begin
            phy_mem[i] = 16'h5A00 + 16'(i);
            shadow[i]  = 16'h5A00 + 16'(i);
        end
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mdc, "R1 mdc low", 64'(mdc), 64'd0);
        chk(!mdio_oe, "R1 enable low", 64'(mdio_oe), 64'd0);
        chk(!csr_wait, "R1 wait low", 64'(csr_wait), 64'd0);
        access(1'b1, 1'b0, 32'h0, rd, cyc);
        chk(rd == 32'h0, "R1 address window reset", 64'(rd), 64'd0);

        // R2 R9: fields at their positions, upper bits dropped
        access(1'b1, 1'b1, 32'hFFFF_FFFF, rd, cyc);
        chk(cyc == 0, "R2 address write immediate", 64'(cyc), 64'd0);
        access(1'b1, 1'b0, 32'h0, rd, cyc);
        chk(rd == 32'h03FF_FFFF, "R2 R9 address readback", 64'(rd), 64'h03FF_FFFF);
        access(1'b1, 1'b1, 32'hA81F_1234, rd, cyc);
        access(1'b1, 1'b0, 32'h0, rd, cyc);
        chk(rd == 32'h001F_1234, "R2 R9 field layout", 64'(rd), 64'h001F_1234);

        // Directed corners
        data_op(1'b0, 5'd3, 5'd1, 16'h0007, 32'h0);
        data_op(1'b1, 5'd31, 5'd31, 16'hFFFF, 32'h0000_0000);
        data_op(1'b0, 5'd31, 5'd31, 16'hFFFF, 32'h0);
        data_op(1'b1, 5'd0, 5'd0, 16'h0000, 32'hDEAD_FFFF);
        data_op(1'b0, 5'd0, 5'd0, 16'h0000, 32'h0);
        data_op(1'b1, 5'd21, 5'd10, 16'hAAAA, 32'h1234_A5C3);
        data_op(1'b0, 5'd10, 5'd21, 16'h000A, 32'h0);

        // Random mix
        for (int k = 0; k < 18; k++) begin
            data_op(1'($urandom()), 5'($urandom()), 5'($urandom()), 16'($urandom()), $urandom());
        end

        finish_run();
    end

endmodule